// File: doc/BRIEF.md
# EDO DRAM Refresh and Initialization Sequencer

This block owns the RAS, CAS and WE strobes of an asynchronous EDO DRAM for everything except ordinary data accesses. After reset it waits out the power-up pause and then runs a burst of dummy CAS-before-RAS (CBR) cycles. After that it keeps the array alive with evenly spaced CBR refreshes. On request it parks the device in self refresh and later brings it back out. An external access controller borrows the strobes through a request/grant handshake. While it holds them, its strobe values pass straight through to the pins, one register stage late.

Refresh takes priority over the host. A refresh that comes due while the host holds the bus is recorded in a small saturating counter. All recorded refreshes run back to back once the host drops its request. Every timing value is a cycle-count parameter. The defaults are derived from a clock-frequency parameter, and a bench or an integrator can override any of them.

Top module: `edo_refresh_seq`

## Requirements
- R1: During reset, ras_no, cas_no and we_no are high, host_gnt_o is 0 and ready_o is 0.
- R2: After reset is released, no strobe moves for at least T_INIT cycles. Then exactly INIT_CYC CBR cycles run, and only after them does ready_o go to 1.
- R3: In every CBR cycle, cas_no falls at least T_CSR cycles before ras_no falls. ras_no stays low for exactly T_RAS cycles. CAS then stays high for at least T_RP cycles before the sequencer drives it low again.
- R4: Whenever the sequencer owns the strobes, we_no is high, including at every RAS falling edge of a refresh.
- R5: While the bus is idle, CBR refreshes occur at a rate of one per T_REFI cycles.
- R6: With nothing owed and the bus idle, host_req_i gets host_gnt_o. While granted, ras_no, cas_no and we_no follow host_ras_ni, host_cas_ni and host_we_ni one cycle later. The grant is removed once host_req_i drops.
- R7: Refresh intervals that expire during a host tenure are counted up to a limit of 4. After the tenure ends they are issued back to back, and host_gnt_o stays low until all of them have finished.
- R8: A self-refresh request (self_req_i, sampled while idle) drops ready_o. It then lowers cas_no, and T_CSR cycles later lowers ras_no. Both stay low.
- R9: In self refresh, wake_i is ignored until RAS has been low for max(T_RASS, T_CHS) cycles, so neither strobe rises earlier.
- R10: After an accepted wake_i, both strobes rise and stay high for at least T_RPS cycles. Exactly one CBR refresh follows before ready_o returns to 1.
- R11: A self-refresh request that arrives during a refresh does not cut that refresh short. Self-refresh entry begins only after its T_RP precharge has elapsed.
- R12: The refresh timer does not run during self refresh and restarts from a full interval. The first periodic refresh after exit comes about T_REFI cycles after ready_o returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| self_req_i | input | 1 | Request to enter self refresh (level, sampled when idle) |
| wake_i | input | 1 | Request to leave self refresh |
| host_req_i | input | 1 | Host bus request; held for the whole tenure |
| host_ras_ni | input | 1 | Host RAS value, used while granted |
| host_cas_ni | input | 1 | Host CAS value, used while granted |
| host_we_ni | input | 1 | Host WE value, used while granted |
| host_gnt_o | output | 1 | Host owns the strobes |
| ready_o | output | 1 | Device initialized and not in self refresh |
| busy_o | output | 1 | Sequencer is running init, refresh or self refresh |
| ras_no | output | 1 | DRAM RAS strobe, active low, registered |
| cas_no | output | 1 | DRAM CAS strobe, active low, registered |
| we_no | output | 1 | DRAM WE strobe, active low, registered |

## Verification
The assertions check four things on every cycle. Each sequencer-owned RAS fall is preceded by a low CAS. WE stays high whenever the host does not own the pins. The owed-refresh count never passes its limit and is only consumed when non-zero. The self-refresh hold ignores wake until its count has expired. Other properties span many cycles or depend on a sequence of inputs, and only the bench scenarios can show them. These are the length of the power-up pause and the number of init cycles, the refresh rate, the saturation and back-to-back flush after a long host tenure, the deferral of self refresh behind an active refresh, and the timer restart after wake.

// File: rtl/edo_ref_pkg.sv
package edo_ref_pkg;
  typedef enum logic [3:0] {
    ST_PWR, ST_INITREF, ST_IDLE, ST_HOST, ST_REF,
    ST_SR_CAS, ST_SR_HOLD, ST_SR_PRE, ST_SR_CBR
  } seq_st_e;

  typedef enum logic [1:0] {PH_IDLE, PH_CAS, PH_RAS, PH_PRE} cbr_ph_e;

  localparam int PEND_W = 3;
endpackage

// File: rtl/edo_cbr_engine.sv
module edo_cbr_engine import edo_ref_pkg::*; #(
  parameter int T_CSR = 1,
  parameter int T_RAS = 6,
  parameter int T_RP  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic cas_lo_o,
  output logic ras_lo_o,
  output logic done_o,
  output logic idle_o
);
  localparam int M1 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int M2 = (M1 > T_RP) ? M1 : T_RP;
  localparam int CW = $clog2(M2 + 1);
  localparam logic [CW-1:0] L_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);

  cbr_ph_e ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin ph_q <= PH_CAS; cnt_q <= L_CSR; end
        PH_CAS:  if (cnt_q == 0) begin ph_q <= PH_RAS; cnt_q <= L_RAS; end
                 else cnt_q <= cnt_q - 1'b1;
        PH_RAS:  if (cnt_q == 0) begin ph_q <= PH_PRE; cnt_q <= L_RP; end
                 else cnt_q <= cnt_q - 1'b1;
        PH_PRE:  if (cnt_q == 0) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cas_lo_o = (ph_q == PH_CAS) || (ph_q == PH_RAS);
  assign ras_lo_o = (ph_q == PH_RAS);
  assign done_o   = (ph_q == PH_PRE) && (cnt_q == 0);
  assign idle_o   = (ph_q == PH_IDLE);

  // start only accepted from idle, never mid-cycle
  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ph_q == PH_IDLE);
endmodule

// File: rtl/edo_ref_timer.sv
module edo_ref_timer import edo_ref_pkg::*; #(
  parameter int T_REFI   = 1562,
  parameter int PEND_MAX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              take_i,
  output logic [PEND_W-1:0] pend_o
);
  localparam int TW = $clog2(T_REFI + 1);
  localparam logic [TW-1:0] L_REFI = TW'(T_REFI - 1);

  logic [TW-1:0]     tmr_q;
  logic [PEND_W-1:0] pend_q;
  logic              tick;
  logic [PEND_W:0]   pend_sum;

  assign tick     = run_i && (tmr_q == 0);
  assign pend_sum = {1'b0, pend_q} + (PEND_W+1)'(tick) - (PEND_W+1)'(take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= L_REFI;
      pend_q <= '0;
    end else begin
      // halted and held at a full interval while not running
      if (!run_i || tmr_q == 0) tmr_q <= L_REFI;
      else                      tmr_q <= tmr_q - 1'b1;
      pend_q <= (pend_sum > (PEND_W+1)'(PEND_MAX)) ? PEND_W'(PEND_MAX) : pend_sum[PEND_W-1:0];
    end
  end

  assign pend_o = pend_q;

  p_pend_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PEND_W'(PEND_MAX));
  p_take_owed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q != 0);
endmodule

// File: rtl/edo_refresh_seq.sv
module edo_refresh_seq import edo_ref_pkg::*; #(
  parameter int CLK_MHZ  = 100,
  parameter int T_REFI   = CLK_MHZ * 8000 / 512,
  parameter int T_INIT   = CLK_MHZ * 200,
  parameter int INIT_CYC = 8,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = (CLK_MHZ * 60 + 999) / 1000,
  parameter int T_RP     = (CLK_MHZ * 40 + 999) / 1000,
  parameter int T_RASS   = CLK_MHZ * 100,
  parameter int T_CHS    = CLK_MHZ * 100,
  parameter int T_RPS    = (CLK_MHZ * 100 + 999) / 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic self_req_i,
  input  logic wake_i,
  input  logic host_req_i,
  input  logic host_ras_ni,
  input  logic host_cas_ni,
  input  logic host_we_ni,
  output logic host_gnt_o,
  output logic ready_o,
  output logic busy_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  localparam int T_HOLD = (T_RASS > T_CHS) ? T_RASS : T_CHS;
  localparam int M1 = (T_INIT > T_HOLD) ? T_INIT : T_HOLD;
  localparam int M2 = (M1 > T_RPS) ? M1 : T_RPS;
  localparam int M3 = (M2 > T_CSR) ? M2 : T_CSR;
  localparam int LW = $clog2(M3 + 1);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam logic [LW-1:0] L_INIT = LW'(T_INIT - 1);
  localparam logic [LW-1:0] L_CSR  = LW'(T_CSR - 1);
  localparam logic [LW-1:0] L_HOLD = LW'(T_HOLD - 1);
  localparam logic [LW-1:0] L_RPS  = LW'(T_RPS - 1);

  seq_st_e           st_q;
  logic [LW-1:0]     cnt_q;
  logic [IW-1:0]     init_q;
  logic              eng_start, eng_done, eng_idle, eng_cas, eng_ras;
  logic [PEND_W-1:0] pend;
  logic              take, t_run;
  logic              ras_d, cas_d, we_d, out_host_q;

  edo_cbr_engine #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_eng (
    .clk_i, .rst_ni, .start_i(eng_start),
    .cas_lo_o(eng_cas), .ras_lo_o(eng_ras), .done_o(eng_done), .idle_o(eng_idle)
  );

  edo_ref_timer #(.T_REFI(T_REFI), .PEND_MAX(4)) u_tmr (
    .clk_i, .rst_ni, .run_i(t_run), .take_i(take), .pend_o(pend)
  );

  assign t_run = (st_q == ST_IDLE) || (st_q == ST_HOST) || (st_q == ST_REF);

  always_comb begin
    eng_start = 1'b0;
    take      = 1'b0;
    unique case (st_q)
      ST_INITREF: eng_start = eng_idle && (init_q != 0);
      ST_IDLE:    if (pend != 0) begin eng_start = 1'b1; take = 1'b1; end
      ST_SR_PRE:  eng_start = (cnt_q == 0);
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PWR;
      cnt_q  <= L_INIT;
      init_q <= IW'(INIT_CYC);
    end else begin
      unique case (st_q)
        ST_PWR:     if (cnt_q == 0) st_q <= ST_INITREF; else cnt_q <= cnt_q - 1'b1;
        ST_INITREF: begin
          if (eng_start) init_q <= init_q - 1'b1;
          if (eng_done && init_q == 0) st_q <= ST_IDLE;
        end
        ST_IDLE: begin
          // refresh owed > self refresh > host
          if (pend != 0)       st_q <= ST_REF;
          else if (self_req_i) begin st_q <= ST_SR_CAS; cnt_q <= L_CSR; end
          else if (host_req_i) st_q <= ST_HOST;
        end
        ST_REF:     if (eng_done) st_q <= ST_IDLE;
        ST_HOST:    if (!host_req_i) st_q <= ST_IDLE;
        ST_SR_CAS:  if (cnt_q == 0) begin st_q <= ST_SR_HOLD; cnt_q <= L_HOLD; end
                    else cnt_q <= cnt_q - 1'b1;
        ST_SR_HOLD: if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
                    else if (wake_i) begin st_q <= ST_SR_PRE; cnt_q <= L_RPS; end
        ST_SR_PRE:  if (cnt_q == 0) st_q <= ST_SR_CBR; else cnt_q <= cnt_q - 1'b1;
        ST_SR_CBR:  if (eng_done) st_q <= ST_IDLE;
        default:    st_q <= ST_PWR;
      endcase
    end
  end

  always_comb begin
    ras_d = ~eng_ras;
    cas_d = ~eng_cas;
    we_d  = 1'b1;
    unique case (st_q)
      ST_HOST:    begin ras_d = host_ras_ni; cas_d = host_cas_ni; we_d = host_we_ni; end
      ST_SR_CAS:  begin ras_d = 1'b1; cas_d = 1'b0; end
      ST_SR_HOLD: begin ras_d = 1'b0; cas_d = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_no     <= 1'b1;
      cas_no     <= 1'b1;
      we_no      <= 1'b1;
      out_host_q <= 1'b0;
    end else begin
      ras_no     <= ras_d;
      cas_no     <= cas_d;
      we_no      <= we_d;
      out_host_q <= (st_q == ST_HOST);
    end
  end

  assign host_gnt_o = (st_q == ST_HOST);
  assign ready_o    = t_run;
  assign busy_o     = !((st_q == ST_IDLE) || (st_q == ST_HOST));

  p_cbr_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && !out_host_q) |-> $past(!cas_no));
  p_we_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_host_q |-> we_no);
  p_wake_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SR_HOLD && cnt_q != 0) |=> st_q == ST_SR_HOLD);
  p_no_host_in_cbr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOST) |-> !eng_cas);
endmodule

// File: tb/edo_refresh_seq_bench.sv
module edo_refresh_seq_bench;
  localparam int T_INIT = 50, INIT_CYC = 8, T_REFI = 60, T_CSR = 2, T_RAS = 4;
  localparam int T_RP = 3, T_RASS = 40, T_CHS = 30, T_RPS = 5;
  localparam int T_HOLD = 40;

  logic clk = 0, rst_n = 0;
  logic self_req = 0, wake = 0, host_req = 0;
  logic h_ras = 1, h_cas = 1, h_we = 1;
  logic gnt, ready, busy, ras_n, cas_n, we_n;

  always #2 clk = ~clk;

  edo_refresh_seq #(.CLK_MHZ(250), .T_REFI(T_REFI), .T_INIT(T_INIT), .INIT_CYC(INIT_CYC),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS), .T_CHS(T_CHS), .T_RPS(T_RPS))
  u_edo_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .self_req_i(self_req), .wake_i(wake),
    .host_req_i(host_req), .host_ras_ni(h_ras), .host_cas_ni(h_cas), .host_we_ni(h_we),
    .host_gnt_o(gnt), .ready_o(ready), .busy_o(busy),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // strobe monitor, sampled at negedge
  logic p_ras = 1, p_cas = 1, gnt_prev = 0;
  int ras_falls = 0, cas_low_run = 0, cas_high_run = 0, ras_low_run = 0;
  int first_cas_fall = -1, last_cas_gap = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ras_falls = 0; cas_low_run = 0; cas_high_run = 0; ras_low_run = 0;
      first_cas_fall = -1; p_ras = 1; p_cas = 1; gnt_prev = 0;
    end else begin
      if (!gnt_prev) begin
        if (p_ras && !ras_n) begin
          ras_falls++;
          chk(cas_low_run >= T_CSR, "R3 cas lead", cas_low_run, T_CSR);
          chk(we_n == 1'b1, "R4 we at ras fall", we_n, 1);
        end
        if (!p_ras && ras_n)
          chk(ras_low_run == T_RAS || ras_low_run >= T_HOLD, "R3 ras width", ras_low_run, T_RAS);
        if (p_cas && !cas_n) begin
          last_cas_gap = cas_high_run;
          if (first_cas_fall < 0) first_cas_fall = cyc;
          chk(cas_high_run >= T_RP, "R3 precharge", cas_high_run, T_RP);
        end
      end
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      cas_high_run = cas_n ? cas_high_run + 1 : 0;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      p_ras = ras_n; p_cas = cas_n; gnt_prev = gnt;
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_for(input string what, ref logic sig, input logic val, input int lim);
    int n = 0;
    while (sig !== val && n < lim) begin @(negedge clk); n++; end
    chk(sig === val, what, sig, val);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
    chk(!gnt && !ready, "R1 gnt/ready low", {gnt, ready}, 0);
  endtask

  task automatic t_init;
    int rel;
    @(negedge clk); rst_n = 1; rel = cyc;
    wait_for("R2 ready after init", ready, 1'b1, 400);
    chk(ras_falls == INIT_CYC, "R2 init cycle count", ras_falls, INIT_CYC);
    chk(first_cas_fall - rel >= T_INIT, "R2 power-up pause", first_cas_fall - rel, T_INIT);
  endtask

  task automatic t_periodic;
    int f0 = ras_falls;
    repeat (10 * T_REFI) @(negedge clk);
    chk(ras_falls - f0 >= 9 && ras_falls - f0 <= 11, "R5 refresh rate", ras_falls - f0, 10);
  endtask

  task automatic t_host;
    host_req = 1;
    wait_for("R6 grant", gnt, 1'b1, 40);
    h_ras = 0; h_we = 0;
    @(negedge clk);
    chk(!ras_n && !we_n && cas_n, "R6 pass-through", {ras_n, cas_n, we_n}, 2);
    h_ras = 1; h_we = 1;
    @(negedge clk); host_req = 0;
    repeat (2) @(negedge clk);
    chk(!gnt, "R6 grant released", gnt, 0);
  endtask

  task automatic t_owed;
    int f0;
    host_req = 1;
    wait_for("R7 grant", gnt, 1'b1, 40);
    repeat (400) @(negedge clk);
    host_req = 0;
    @(negedge clk);
    host_req = 1; f0 = ras_falls;
    wait_for("R7 regrant", gnt, 1'b1, 100);
    chk(ras_falls - f0 >= 4 && ras_falls - f0 <= 5, "R7 owed flush", ras_falls - f0, 4);
    host_req = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic exit_sr(input int lead);
    repeat (lead) @(negedge clk);
    wake = 1; @(negedge clk); wake = 0;
    wait_for("R10 ready after wake", ready, 1'b1, 100);
  endtask

  task automatic t_defer;
    int f0 = ras_falls, n = 0;
    while (ras_falls == f0 && n < 100) begin @(negedge clk); n++; end
    self_req = 1;
    wait_for("R11 sr entered", ready, 1'b0, 40);
    self_req = 0;
    repeat (2) @(negedge clk);
    chk(!cas_n && last_cas_gap >= T_RP, "R11 entry after precharge", last_cas_gap, T_RP);
    exit_sr(50);
  endtask

  task automatic t_selfref;
    int fall, f0, f1, n = 0;
    @(negedge clk); self_req = 1;
    wait_for("R8 ready drops", ready, 1'b0, 40);
    self_req = 0;
    while (ras_n && n < 40) begin @(negedge clk); n++; end
    fall = cyc;
    chk(!ras_n && !cas_n, "R8 both low", {ras_n, cas_n}, 0);
    repeat (10) @(negedge clk);
    wake = 1; @(negedge clk); wake = 0;
    repeat (3) @(negedge clk);
    chk(!ras_n && !cas_n, "R9 early wake ignored", {ras_n, cas_n}, 0);
    repeat (T_HOLD - 10) @(negedge clk);
    f0 = ras_falls;
    wake = 1; @(negedge clk); wake = 0;
    n = 0;
    while (!ras_n && n < 10) begin @(negedge clk); n++; end
    chk(cyc - fall >= T_HOLD, "R9 hold length", cyc - fall, T_HOLD);
    wait_for("R10 ready", ready, 1'b1, 100);
    chk(ras_falls - f0 == 1, "R10 one exit CBR", ras_falls - f0, 1);
    chk(last_cas_gap >= T_RPS, "R10 exit precharge", last_cas_gap, T_RPS);
    f1 = ras_falls;
    repeat (T_REFI - 6) @(negedge clk);
    chk(ras_falls == f1, "R12 timer restarted", ras_falls - f1, 0);
    repeat (14) @(negedge clk);
    chk(ras_falls == f1 + 1, "R12 first refresh", ras_falls - f1, 1);
  endtask

  initial begin
    t_reset;
    t_init;
    t_periodic;
    t_host;
    t_owed;
    t_defer;
    t_selfref;
    t_periodic;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule